// File: doc/BRIEF.md
# Host-Bus Access Cycle Sequencer

This block turns single read and write requests into timed cycles on an external parallel host bus for one chip select. A requester presents an address, write data and a direction with a valid flag. It holds them until the block pulses ready, which marks the end of the bus cycle. For reads, the captured bus data is shown on the response bus in the ready clock. The block drives a shared address/data bus with an output enable, a separate address bus, and active-high address-latch, write, read and chip-select strobes.

The timing and bus arrangement come from a small set of configuration inputs. A global sub-mode is used unless the chip-select override enable is set. When the override is set, a per-chip-select sub-mode, a write wait-state count, a one-clock trim bit and a burst enable take effect. Three sub-modes are supported. The first multiplexes address and data on the shared bus behind an address-latch pulse. The second keeps the address on the separate address bus. The third is a continuous-read variant of the second: it holds the read strobe across back-to-back reads and only switches the address. Configuration is sampled when a request is accepted from idle.

Top module: `hbCycleSeq`

## Requirements
- R1: With the override enable set, burst not in effect and trim clear, a write holds the write strobe for 2*(W+1) clocks, where W is the 2-bit wait-state code (0..3 gives 2, 4, 6, 8).
- R2: With the override enable set, burst not in effect and trim set, the write strobe lasts one clock less than in R1 (code 0 gives 1 clock).
- R3: With the override enable clear, the global sub-mode is used and every write strobe lasts 2 clocks, whatever the per-chip-select sub-mode, wait-state, trim and burst inputs are.
- R4: Burst is in effect only when the burst input is set and the resolved sub-mode is multiplexed. A write in burst holds the strobe for 2 clocks regardless of wait states and trim. A burst request in any other sub-mode behaves as non-burst.
- R5: Sub-mode code 3 behaves exactly like code 0 (multiplexed). Code 1 is separate address/data and code 2 is continuous read.
- R6: In the multiplexed sub-mode, the address-latch strobe is high for exactly one clock, the clock before the first data strobe. In that clock the output enable is high and the shared bus carries the address. During the strobe, the shared bus carries the write data (output enable high) for writes and is released (output enable low) for reads. The separate address bus stays 0.
- R7: In the separate and continuous-read sub-modes, no address-latch pulse occurs and the separate address bus carries the request address during every strobe clock. For writes, the shared bus drives the write data.
- R8: A read holds the read strobe for 2 clocks. The response data equals the shared-bus input value present in the last strobe clock, and it is valid in the ready clock.
- R9: Ready is high for exactly one clock per completed request, and never outside a cycle.
- R10: Chip select rises one clock before the first strobe, and wait states do not lengthen that address clock. It stays high for one clock after the last strobe and is low at reset.
- R11: After a completed cycle that ends with the read strobe low, chip select is low for at least one clock before any further cycle.
- R12: In continuous-read sub-mode, if a new read request is valid in the clock after ready, the read strobe stays high without a break. The separate address bus switches to the new address for the next 2 strobe clocks, with no new setup clock. When no read follows, the strobe falls and chip select drops one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present; held until reqReady |
| reqReady | output | 1 | One-clock pulse at the end of a cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | AW (16) | Request address |
| reqWdata | input | DW (16) | Write data |
| rspData | output | DW (16) | Read data, valid with reqReady on reads |
| cfgGlobalMode | input | 2 | Sub-mode used when the override is clear |
| cfgCsMode | input | 2 | Per-chip-select sub-mode |
| cfgCsOverride | input | 1 | Enables the per-chip-select fields |
| cfgWrWait | input | WS_W (2) | Write wait-state code |
| cfgWrTrim | input | 1 | Shortens the write strobe by one clock |
| cfgBurst | input | 1 | Burst request |
| busIn | input | DW (16) | Shared bus input value |
| busOut | output | DW (16) | Shared bus output value |
| busOe | output | 1 | Shared bus output enable |
| pinAddr | output | AW (16) | Separate address bus |
| pinAle | output | 1 | Address-latch strobe |
| pinWr | output | 1 | Write strobe |
| pinRd | output | 1 | Read / output-enable strobe |
| pinCs | output | 1 | Chip select |

## Verification
In continuous-read sub-mode, the completion of one read and the start of the next overlap. The ready pulse of the first read comes while the read strobe is still high, and the next address is taken while that same strobe is held. The bench provokes this by keeping valid high and changing the address in the ready clock. It then checks that the read strobe never drops, that no setup clock or address-latch pulse appears, and that both response values match the bus input in each read's last strobe clock. A second overlap is checked across a full sweep: the trim and the wait-state code both act on the same strobe counter, and the bench compares each measured strobe width with the value computed from the code, the trim, the override and the burst.

// File: rtl/hbSeqPkg.sv
package hbSeqPkg;

  typedef enum logic [1:0] {
    MODE_MUX  = 2'd0,
    MODE_SEP  = 2'd1,
    MODE_CONT = 2'd2,
    MODE_RSVD = 2'd3
  } subMode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_CHAIN,
    ST_LINGER,
    ST_CLOSE
  } hbState_t;

  typedef struct packed {
    logic latchReq;
    logic captureRd;
    logic phaseAddr;
    logic driveWr;
    logic sepAddr;
  } hbStrobe_t;

endpackage

// File: rtl/hbSeqCtrl.sv
module hbSeqCtrl
  import hbSeqPkg::*;
#(
  parameter int WS_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            reqWrite,
  input  logic [1:0]      cfgGlobalMode,
  input  logic [1:0]      cfgCsMode,
  input  logic            cfgCsOverride,
  input  logic [WS_W-1:0] cfgWrWait,
  input  logic            cfgWrTrim,
  input  logic            cfgBurst,
  output logic            reqReady,
  output logic            pinAle,
  output logic            pinWr,
  output logic            pinRd,
  output logic            pinCs,
  output hbStrobe_t       strb
);

  localparam int CNT_W = WS_W + 1;

  hbState_t           stQ;
  subMode_t           modeQ;
  logic               wrQ;
  logic [CNT_W-1:0]   cntQ;
  logic [CNT_W-1:0]   widthM1Q;

  subMode_t           effMode;
  logic               burstEff;
  logic [CNT_W-1:0]   newWidthM1;
  logic               accept;
  logic               chainGo;
  logic               lastBeat;
  logic               isMux;

  // Resolve sub-mode; reserved code folds onto multiplexed.
  always_comb begin
    effMode = cfgCsOverride ? subMode_t'(cfgCsMode) : subMode_t'(cfgGlobalMode);
    if (effMode == MODE_RSVD) effMode = MODE_MUX;
    burstEff = cfgBurst && (effMode == MODE_MUX);
    if (reqWrite && cfgCsOverride && !burstEff)
      newWidthM1 = {cfgWrWait, 1'b1} - CNT_W'(cfgWrTrim);
    else
      newWidthM1 = CNT_W'(1);
  end

  assign accept   = (stQ == ST_IDLE) && reqValid;
  assign chainGo  = (stQ == ST_LINGER) && reqValid && !reqWrite;
  assign lastBeat = (stQ == ST_STROBE) && (cntQ == '0);
  assign isMux    = (modeQ == MODE_MUX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ      <= ST_IDLE;
      modeQ    <= MODE_MUX;
      wrQ      <= 1'b0;
      cntQ     <= '0;
      widthM1Q <= '0;
    end else begin
      unique case (stQ)
        ST_IDLE: if (accept) begin
          stQ      <= ST_SETUP;
          modeQ    <= effMode;
          wrQ      <= reqWrite;
          widthM1Q <= newWidthM1;
        end
        ST_SETUP: begin
          stQ  <= ST_STROBE;
          cntQ <= widthM1Q;
        end
        ST_STROBE: begin
          if (cntQ == '0)
            stQ <= (!wrQ && modeQ == MODE_CONT) ? ST_CHAIN : ST_HOLD;
          else
            cntQ <= cntQ - CNT_W'(1);
        end
        ST_CHAIN:  stQ <= ST_LINGER;
        ST_LINGER: begin
          if (chainGo) begin
            stQ  <= ST_STROBE;
            cntQ <= CNT_W'(1);
          end else begin
            stQ <= ST_CLOSE;
          end
        end
        ST_HOLD:   stQ <= ST_IDLE;
        ST_CLOSE:  stQ <= ST_IDLE;
        default:   stQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    pinCs    = (stQ != ST_IDLE);
    pinAle   = (stQ == ST_SETUP) && isMux;
    pinWr    = (stQ == ST_STROBE) && wrQ;
    pinRd    = ((stQ == ST_STROBE) && !wrQ) || (stQ == ST_CHAIN) || (stQ == ST_LINGER);
    reqReady = (stQ == ST_HOLD) || (stQ == ST_CHAIN);

    strb.latchReq  = accept || chainGo;
    strb.captureRd = lastBeat && !wrQ;
    strb.phaseAddr = (stQ == ST_SETUP) && isMux;
    strb.driveWr   = wrQ && ((stQ == ST_STROBE) || ((stQ == ST_SETUP) && !isMux));
    strb.sepAddr   = pinCs && !isMux;
  end

  // R9: ready never lasts two clocks
  assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady);

  // R10: no strobe in the first chip-select clock
  assert_cs_lead_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinCs) |-> (!pinWr && !pinRd));

  // R10: no strobe in the last chip-select clock
  assert_cs_trail_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pinCs) |-> $past(!pinWr && !pinRd));

  // R11: a completed cycle with the read strobe low leaves an idle clock
  assert_idle_gap_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !pinRd) |=> !pinCs);

  // R6: address-latch pulse is alone and lasts one clock
  assert_ale_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    pinAle |-> (pinCs && !pinWr && !pinRd) ##1 !pinAle);

endmodule

// File: rtl/hbSeqData.sv
module hbSeqData
  import hbSeqPkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  hbStrobe_t     strb,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  input  logic [DW-1:0] busIn,
  output logic [DW-1:0] busOut,
  output logic          busOe,
  output logic [AW-1:0] pinAddr,
  output logic [DW-1:0] rspData
);

  logic [AW-1:0] addrQ;
  logic [DW-1:0] wdQ;
  logic [DW-1:0] rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      wdQ   <= '0;
      rdQ   <= '0;
    end else begin
      if (strb.latchReq) begin
        addrQ <= reqAddr;
        wdQ   <= reqWdata;
      end
      if (strb.captureRd) rdQ <= busIn;
    end
  end

  always_comb begin
    busOe   = strb.phaseAddr || strb.driveWr;
    busOut  = strb.phaseAddr ? DW'(addrQ) : wdQ;
    pinAddr = strb.sepAddr ? addrQ : '0;
    rspData = rdQ;
  end

  // R8: bus is released while read data is captured
  assert_bus_free_on_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureRd |-> !busOe);

  // R6: address phase never overlaps data drive
  assert_phase_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.phaseAddr && strb.driveWr));

endmodule

// File: rtl/hbCycleSeq.sv
module hbCycleSeq
  import hbSeqPkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int WS_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic            reqWrite,
  input  logic [AW-1:0]   reqAddr,
  input  logic [DW-1:0]   reqWdata,
  output logic [DW-1:0]   rspData,
  input  logic [1:0]      cfgGlobalMode,
  input  logic [1:0]      cfgCsMode,
  input  logic            cfgCsOverride,
  input  logic [WS_W-1:0] cfgWrWait,
  input  logic            cfgWrTrim,
  input  logic            cfgBurst,
  input  logic [DW-1:0]   busIn,
  output logic [DW-1:0]   busOut,
  output logic            busOe,
  output logic [AW-1:0]   pinAddr,
  output logic            pinAle,
  output logic            pinWr,
  output logic            pinRd,
  output logic            pinCs
);

  hbStrobe_t strb;

  hbSeqCtrl #(.WS_W(WS_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .cfgGlobalMode(cfgGlobalMode), .cfgCsMode(cfgCsMode),
    .cfgCsOverride(cfgCsOverride), .cfgWrWait(cfgWrWait),
    .cfgWrTrim(cfgWrTrim), .cfgBurst(cfgBurst),
    .reqReady(reqReady), .pinAle(pinAle), .pinWr(pinWr),
    .pinRd(pinRd), .pinCs(pinCs), .strb(strb)
  );

  hbSeqData #(.AW(AW), .DW(DW)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .pinAddr(pinAddr), .rspData(rspData)
  );

endmodule

// File: tb/hbCycleSeq_tb_top.sv
`timescale 1ns/1ps
module hbCycleSeq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0, busIn = 16'h1234;
  logic [1:0]  cfgGlobalMode = '0, cfgCsMode = '0, cfgWrWait = '0;
  logic        cfgCsOverride = 1'b0, cfgWrTrim = 1'b0, cfgBurst = 1'b0;
  logic        reqReady, busOe, pinAle, pinWr, pinRd, pinCs;
  logic [15:0] rspData, busOut, pinAddr;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hbCycleSeq dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspData(rspData), .cfgGlobalMode(cfgGlobalMode), .cfgCsMode(cfgCsMode),
    .cfgCsOverride(cfgCsOverride), .cfgWrWait(cfgWrWait),
    .cfgWrTrim(cfgWrTrim), .cfgBurst(cfgBurst), .busIn(busIn),
    .busOut(busOut), .busOe(busOe), .pinAddr(pinAddr), .pinAle(pinAle),
    .pinWr(pinWr), .pinRd(pinRd), .pinCs(pinCs)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // One non-chained request, starting at a negedge, ending one clock after ready.
  task automatic runXfer(input bit isWr, input logic [15:0] a, input logic [15:0] d,
                         input bit expMux, input int expW, input string wTag);
    int n = 0, readyIdx = 0, strobeCnt = 0, aleCnt = 0;
    bit aleOk = 1, dataOk = 1, addrOk = 1, firstOk = 0, lastOk = 0, done = 0;
    logic [15:0] expRd = '0, gotRd = '0;
    reqValid = 1; reqWrite = isWr; reqAddr = a; reqWdata = d;
    while (!done && n < 60) begin
      @(negedge clk); n++;
      if (n == 1) firstOk = pinCs && !pinWr && !pinRd && !reqReady;
      if (pinAle) begin
        aleCnt++;
        aleOk &= busOe && (busOut == a) && !pinWr && !pinRd;
      end
      if (pinWr || pinRd) begin
        strobeCnt++;
        addrOk &= (pinAddr == (expMux ? 16'h0 : a));
      end
      if (pinWr) dataOk &= busOe && (busOut == d);
      if (pinRd) dataOk &= !busOe;
      if (reqReady) begin
        done = 1; readyIdx = n; gotRd = rspData;
        lastOk = pinCs && !pinWr && !pinRd;
      end
      busIn = busIn + 16'h03b5;
      if (pinRd && !reqReady) expRd = busIn;
    end
    reqValid = 0;
    check(done, "R9 ready seen", int'(done), 1);
    check(strobeCnt == expW, wTag, strobeCnt, expW);
    check(firstOk && strobeCnt == readyIdx - 2, "R10 setup clock", readyIdx, strobeCnt + 2);
    check(lastOk, "R10 trailing chip select", int'(lastOk), 1);
    check(aleCnt == (expMux ? 1 : 0) && aleOk, expMux ? "R6 ale" : "R7 no ale", aleCnt, expMux ? 1 : 0);
    check(dataOk, expMux ? "R6 bus data" : "R7 bus data", int'(dataOk), 1);
    check(addrOk, expMux ? "R6 addr bus zero" : "R7 addr bus", int'(addrOk), 1);
    if (!isWr) check(gotRd == expRd, "R8 read data", gotRd, expRd);
    @(negedge clk);
    check(!pinCs && !reqReady, "R11 idle gap / R9 single pulse", int'(pinCs), 0);
  endtask

  initial begin
    #(8 * 150000);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!pinCs && !reqReady && !pinWr && !pinRd && !busOe, "R10 reset state", int'(pinCs), 0);
    rstN = 1;
    @(negedge clk);

    // Write sweep: R1, R2, R3, R4, R5
    for (int ov = 0; ov < 2; ov++)
      for (int cm = 0; cm < 4; cm++)
        for (int gm = 0; gm < 2; gm++)
          for (int ww = 0; ww < 4; ww++)
            for (int tr = 0; tr < 2; tr++)
              for (int bu = 0; bu < 2; bu++) begin
                int em, w;
                bit mux, be;
                string tag;
                cfgCsOverride = ov[0]; cfgCsMode = cm[1:0]; cfgGlobalMode = gm[1:0];
                cfgWrWait = ww[1:0]; cfgWrTrim = tr[0]; cfgBurst = bu[0];
                em = ov ? cm : gm;
                mux = (em == 0) || (em == 3);
                be = bu[0] && mux;
                if (!ov) begin w = 2; tag = "R3 global width"; end
                else if (be) begin w = 2; tag = "R4 burst width"; end
                else begin
                  w = 2 * (ww + 1) - tr;
                  tag = tr ? "R2 trimmed width" : (bu ? "R4 burst ignored width" : "R1 width");
                end
                if (ov && cm == 3) tag = {tag, " R5"};
                runXfer(1'b1, 16'(16'hA000 + ov*256 + cm*64 + ww*8 + tr*2 + bu),
                        16'(16'h5000 ^ (cm*97 + ww*13 + tr*5 + bu)), mux, w, tag);
              end

    // Reads in multiplexed, reserved and separate sub-modes: R8, R6, R7, R5
    for (int cm = 0; cm < 4; cm++) begin
      if (cm == 2) continue;
      for (int k = 0; k < 3; k++) begin
        cfgCsOverride = 1; cfgCsMode = cm[1:0]; cfgWrWait = 2'd3; cfgBurst = k[0];
        runXfer(1'b0, 16'(16'h3000 + cm*16 + k), 16'h0, cm != 1, 2, "R8 read width");
      end
    end

    // Continuous read: R12
    begin
      int n = 0, readies = 0;
      bit brk = 0, addrOk = 1, aleSeen = 0;
      logic [15:0] expRd = '0;
      cfgCsOverride = 1; cfgCsMode = 2'd2;
      reqValid = 1; reqWrite = 0; reqAddr = 16'h4411;
      while (readies < 2 && n < 40) begin
        @(negedge clk); n++;
        if (pinAle) aleSeen = 1;
        if (n >= 2 && pinCs && !pinRd) brk = 1;
        if (readies == 1 && pinRd && !reqReady && n >= 6) addrOk &= (pinAddr == 16'h4422);
        if (readies == 0 && pinRd && !reqReady) addrOk &= (pinAddr == 16'h4411);
        if (reqReady) begin
          readies++;
          check(rspData == expRd, "R12 chained read data R8", rspData, expRd);
          check(pinRd, "R12 strobe held at ready", int'(pinRd), 1);
          if (readies == 1) reqAddr = 16'h4422;
          else reqValid = 0;
        end
        busIn = busIn + 16'h0101;
        if (pinRd && !reqReady) expRd = busIn;
      end
      check(readies == 2 && n == 8, "R12 chained timing", n, 8);
      check(!brk && !aleSeen, "R12 no strobe break", int'(brk), 0);
      check(addrOk, "R12 address switch", int'(addrOk), 1);
      @(negedge clk);
      check(pinCs && pinRd && !reqReady, "R12 linger", int'(pinRd), 1);
      @(negedge clk);
      check(pinCs && !pinRd, "R12 close", int'(pinRd), 0);
      @(negedge clk);
      check(!pinCs, "R12 R11 idle after chain", int'(pinCs), 0);
    end

    // Continuous-read sub-mode write is a plain separate-bus write: R7
    cfgCsOverride = 1; cfgCsMode = 2'd2; cfgWrWait = 2'd1; cfgWrTrim = 0; cfgBurst = 1;
    runXfer(1'b1, 16'h7777, 16'hBEEF, 1'b0, 4, "R4 burst ignored in continuous mode R7");

    summary();
  end

endmodule